// File: doc/BRIEF.md
# Gated Hardware-Register Read Unit

This unit serves an instruction that lets unprivileged code read a small set of processor status values. Each request carries a 5-bit register index, a flag that says whether the core is in privileged mode, and a 32-bit enable mask with one bit per index. The unit first decides whether the read is permitted. It then picks the source that the index names and formats that value to the output width. The result comes back one clock after the request.

A read is permitted when the core is privileged, or when the mask bit at the position of the index is set. A read that is not permitted, or that names an index with no source behind it, produces a reserved-instruction fault flag and an all-zero result. The counters and configuration state are kept elsewhere and reach this unit as plain inputs. The unit adds only the gating, the selection and the sign or zero extension of each value.

Top module: `hwreg_read_gate`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with no request, rsp_valid, rsp_fault and rsp_data are all 0.
- R2: A request with req_valid high at a rising edge produces rsp_valid high after that edge, for exactly one cycle per request. A cycle with req_valid low gives rsp_valid low after the next edge, and rsp_data and rsp_fault keep their previous values.
- R3: For indices 0 to 5, the read is granted (rsp_fault = 0) when priv_mode is 1 or when en_mask bit number req_idx is 1.
- R4: For indices 0 to 5 with priv_mode = 0 and en_mask bit req_idx = 0, rsp_fault is 1 and rsp_data is all zero.
- R5: Indices 6 to 31 always give rsp_fault = 1 and rsp_data = 0, whatever priv_mode and en_mask are.
- R6: A granted index 0 returns exc_base_lo (the low CPUNUM_W = 10 bits of the exception base), zero-extended.
- R7: A granted index 1 returns sync_step unchanged.
- R8: A granted index 2 returns the 32-bit cycle_lo, sign-extended from bit 31 to XLEN bits.
- R9: A granted index 3 returns cyc_res unchanged.
- R10: A granted index 4 returns perf0 unchanged.
- R11: A granted index 5 returns cfg_flag in bit 0, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request in this cycle |
| req_idx | input | IDX_W (5) | Register index |
| priv_mode | input | 1 | Privileged mode, bypasses the mask |
| en_mask | input | 2**IDX_W (32) | Per-index read enable |
| exc_base_lo | input | CPUNUM_W (10) | CPU number field of the exception base |
| sync_step | input | XLEN (64) | Cache-line synchronisation step |
| cycle_lo | input | 32 | Low word of the cycle counter |
| cyc_res | input | XLEN (64) | Cycle-counter resolution |
| perf0 | input | XLEN (64) | Performance counter 0 |
| cfg_flag | input | 1 | Status bit from a configuration register |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Reserved-instruction fault |
| rsp_data | output | XLEN (64) | Read result, zero on fault |

## Verification
The bench builds the unit with the default XLEN of 64, IDX_W of 5 and CPUNUM_W of 10. At 64 bits the upper 32 bits of the index-2 result must copy bit 31 of the cycle word, so a sign extension that is missing or wrong can be seen. The 10-bit CPU number and the 1-bit flag leave many upper bits that must be zero. The 32-bit mask allows set bits above index 5, so the bench can confirm that those bits never turn the unimplemented indices into granted reads.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

  // Number of indices that have a source behind them (0 .. NUM_IMPL-1).
  localparam int NUM_IMPL = 6;

  // Source selector; the numeric value equals the register index it serves.
  typedef enum logic [2:0] {
    SRC_CPUNUM   = 3'd0,
    SRC_SYNCSTEP = 3'd1,
    SRC_CYCLES   = 3'd2,
    SRC_CYCRES   = 3'd3,
    SRC_PERF0    = 3'd4,
    SRC_CFGBIT   = 3'd5,
    SRC_NONE     = 3'd7
  } src_sel_e;

endpackage

// File: rtl/hwr_permit.sv
module hwr_permit #(
  parameter int IDX_W  = 5,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              priv,
  input  logic [MASK_W-1:0] mask,
  output logic              grant,
  output hwr_pkg::src_sel_e src_sel
);

  logic implemented;

  // Index-to-source map; indices past the implemented range map to none.
  always_comb begin
    src_sel = hwr_pkg::SRC_NONE;
    for (int k = 0; k < hwr_pkg::NUM_IMPL; k++) begin
      if (idx == IDX_W'(k)) begin
        src_sel = hwr_pkg::src_sel_e'(3'(k));
      end
    end
  end

  assign implemented = (src_sel != hwr_pkg::SRC_NONE);

  // Privileged mode bypasses the mask, but never the implemented check.
  assign grant = implemented && (priv || mask[idx]);

endmodule

// File: rtl/hwr_format.sv
module hwr_format #(
  parameter int XLEN     = 64,
  parameter int CPUNUM_W = 10
) (
  input  hwr_pkg::src_sel_e   src_sel,
  input  logic [CPUNUM_W-1:0] exc_base_lo,
  input  logic [XLEN-1:0]     sync_step,
  input  logic [31:0]         cycle_lo,
  input  logic [XLEN-1:0]     cyc_res,
  input  logic [XLEN-1:0]     perf0,
  input  logic                cfg_flag,
  output logic [XLEN-1:0]     value
);

  logic [XLEN-1:0] cpunum_ext;
  logic [XLEN-1:0] cycles_ext;
  logic [XLEN-1:0] flag_ext;

  assign cpunum_ext = {{(XLEN-CPUNUM_W){1'b0}}, exc_base_lo};
  assign flag_ext   = {{(XLEN-1){1'b0}}, cfg_flag};

  // Sign extension of the 32-bit counter word; a no-op at XLEN = 32.
  generate
    if (XLEN > 32) begin : g_sext
      assign cycles_ext = {{(XLEN-32){cycle_lo[31]}}, cycle_lo};
    end else begin : g_plain
      assign cycles_ext = cycle_lo;
    end
  endgenerate

  always_comb begin
    unique case (src_sel)
      hwr_pkg::SRC_CPUNUM:   value = cpunum_ext;
      hwr_pkg::SRC_SYNCSTEP: value = sync_step;
      hwr_pkg::SRC_CYCLES:   value = cycles_ext;
      hwr_pkg::SRC_CYCRES:   value = cyc_res;
      hwr_pkg::SRC_PERF0:    value = perf0;
      hwr_pkg::SRC_CFGBIT:   value = flag_ext;
      default:               value = '0;
    endcase
  end

endmodule

// File: rtl/hwr_rsp_reg.sv
module hwr_rsp_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            grant,
  input  logic [XLEN-1:0] value,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [XLEN-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= ~grant;
        rsp_data  <= grant ? value : '0;
      end
    end
  end

endmodule

// File: rtl/hwreg_read_gate.sv
module hwreg_read_gate #(
  parameter int XLEN     = 64,
  parameter int IDX_W    = 5,
  parameter int CPUNUM_W = 10,
  localparam int MASK_W  = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic                priv_mode,
  input  logic [MASK_W-1:0]   en_mask,
  input  logic [CPUNUM_W-1:0] exc_base_lo,
  input  logic [XLEN-1:0]     sync_step,
  input  logic [31:0]         cycle_lo,
  input  logic [XLEN-1:0]     cyc_res,
  input  logic [XLEN-1:0]     perf0,
  input  logic                cfg_flag,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [XLEN-1:0]     rsp_data
);

  logic              grant;
  hwr_pkg::src_sel_e src_sel;
  logic [XLEN-1:0]   value;

  hwr_permit #(.IDX_W(IDX_W)) u_permit (
    .idx     (req_idx),
    .priv    (priv_mode),
    .mask    (en_mask),
    .grant   (grant),
    .src_sel (src_sel)
  );

  hwr_format #(.XLEN(XLEN), .CPUNUM_W(CPUNUM_W)) u_format (
    .src_sel     (src_sel),
    .exc_base_lo (exc_base_lo),
    .sync_step   (sync_step),
    .cycle_lo    (cycle_lo),
    .cyc_res     (cyc_res),
    .perf0       (perf0),
    .cfg_flag    (cfg_flag),
    .value       (value)
  );

  hwr_rsp_reg #(.XLEN(XLEN)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .grant     (grant),
    .value     (value),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/hwreg_read_gate_chk.sv
module hwreg_read_gate_chk #(
  parameter int XLEN     = 64,
  parameter int IDX_W    = 5,
  parameter int CPUNUM_W = 10,
  localparam int MASK_W  = 1 << IDX_W
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [IDX_W-1:0]    req_idx,
  input logic                priv_mode,
  input logic [MASK_W-1:0]   en_mask,
  input logic [CPUNUM_W-1:0] exc_base_lo,
  input logic [31:0]         cycle_lo,
  input logic                cfg_flag,
  input logic                rsp_valid,
  input logic                rsp_fault,
  input logic [XLEN-1:0]     rsp_data
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(hwr_pkg::NUM_IMPL);

  logic            in_range;
  logic            permitted;
  logic [XLEN-1:0] sext_cycle;

  assign in_range  = req_idx < LIMIT;
  assign permitted = in_range && (priv_mode || en_mask[req_idx]);

  always_comb begin
    sext_cycle = {XLEN{cycle_lo[31]}};
    sext_cycle[31:0] = cycle_lo;
  end

  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_data) && $stable(rsp_fault)));

  assert_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && permitted) |=> !rsp_fault);

  assert_deny_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_range && !priv_mode && !en_mask[req_idx]) |=> rsp_fault);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_data == '0));

  assert_unimpl_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_range) |=> rsp_fault);

  assert_cpunum_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && permitted && req_idx == '0) |=>
      (rsp_data == {{(XLEN-CPUNUM_W){1'b0}}, $past(exc_base_lo)}));

  assert_sext_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && permitted && req_idx == IDX_W'(2)) |=>
      (rsp_data == $past(sext_cycle)));

  assert_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && permitted && req_idx == IDX_W'(5)) |=>
      (rsp_data == {{(XLEN-1){1'b0}}, $past(cfg_flag)}));

endmodule

bind hwreg_read_gate hwreg_read_gate_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .CPUNUM_W(CPUNUM_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_idx     (req_idx),
  .priv_mode   (priv_mode),
  .en_mask     (en_mask),
  .exc_base_lo (exc_base_lo),
  .cycle_lo    (cycle_lo),
  .cfg_flag    (cfg_flag),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_data    (rsp_data)
);

// File: tb/tb_hwreg_read_gate.sv
module tb_hwreg_read_gate;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int IDX_W = 5;
  localparam int CPUNUM_W = 10;

  logic                clk = 1'b0;
  logic                rst;
  logic                req_valid;
  logic [IDX_W-1:0]    req_idx;
  logic                priv_mode;
  logic [31:0]         en_mask;
  logic [CPUNUM_W-1:0] exc_base_lo;
  logic [XLEN-1:0]     sync_step;
  logic [31:0]         cycle_lo;
  logic [XLEN-1:0]     cyc_res;
  logic [XLEN-1:0]     perf0;
  logic                cfg_flag;
  logic                rsp_valid;
  logic                rsp_fault;
  logic [XLEN-1:0]     rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwreg_read_gate #(.XLEN(XLEN), .IDX_W(IDX_W), .CPUNUM_W(CPUNUM_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .priv_mode(priv_mode), .en_mask(en_mask), .exc_base_lo(exc_base_lo),
    .sync_step(sync_step), .cycle_lo(cycle_lo), .cyc_res(cyc_res),
    .perf0(perf0), .cfg_flag(cfg_flag), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  function automatic bit exp_grant(input logic [4:0] idx, input logic pm,
                                   input logic [31:0] m);
    return (idx < 5'd6) && (pm || m[idx]);
  endfunction

  function automatic logic [XLEN-1:0] exp_value(input logic [4:0] idx);
    case (idx)
      5'd0: return {54'd0, exc_base_lo};
      5'd1: return sync_step;
      5'd2: return {{32{cycle_lo[31]}}, cycle_lo};
      5'd3: return cyc_res;
      5'd4: return perf0;
      5'd5: return {63'd0, cfg_flag};
      default: return '0;
    endcase
  endfunction

  function automatic string req_tag(input logic [4:0] idx, input bit g);
    if (idx >= 5'd6) return "R5";
    if (!g) return "R4";
    case (idx)
      5'd0: return "R6";
      5'd1: return "R7";
      5'd2: return "R8";
      5'd3: return "R9";
      5'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [XLEN+1:0] act,
                       input logic [XLEN+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s valid/fault/data act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic randomize_sources();
    exc_base_lo = CPUNUM_W'($urandom);
    sync_step   = {$urandom, $urandom};
    cycle_lo    = $urandom;
    cyc_res     = {$urandom, $urandom};
    perf0       = {$urandom, $urandom};
    cfg_flag    = 1'($urandom);
  endtask

  // Entered and left at a falling edge; one request, response checked.
  task automatic do_req(input logic [4:0] idx, input logic pm,
                        input logic [31:0] m, input string extra);
    bit g;
    logic [XLEN-1:0] ev;
    req_valid = 1'b1;
    req_idx   = idx;
    priv_mode = pm;
    en_mask   = m;
    g  = exp_grant(idx, pm, m);
    ev = g ? exp_value(idx) : '0;
    @(negedge clk);
    check({req_tag(idx, g), extra}, {rsp_valid, rsp_fault, rsp_data},
          {1'b1, ~g, ev});
  endtask

  task automatic do_idle();
    logic            pf;
    logic [XLEN-1:0] pd;
    pf = rsp_fault;
    pd = rsp_data;
    req_valid = 1'b0;
    randomize_sources();
    req_idx   = 5'($urandom);
    priv_mode = 1'($urandom);
    en_mask   = $urandom;
    @(negedge clk);
    check("R2 idle hold", {rsp_valid, rsp_fault, rsp_data}, {1'b0, pf, pd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a77));
    rst = 1'b1;
    req_valid = 1'b0;
    req_idx = '0;
    priv_mode = 1'b0;
    en_mask = '0;
    randomize_sources();
    repeat (3) @(negedge clk);
    check("R1 in reset", {rsp_valid, rsp_fault, rsp_data}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {rsp_valid, rsp_fault, rsp_data}, '0);

    // R3: privileged bypass with empty mask, then mask-only grant.
    for (int i = 0; i < 6; i++) begin
      randomize_sources();
      do_req(5'(i), 1'b1, 32'h0, " R3 priv");
      randomize_sources();
      do_req(5'(i), 1'b0, 32'h1 << i, " R3 mask");
    end
    // R4: mask set everywhere except the requested bit.
    for (int i = 0; i < 6; i++) begin
      randomize_sources();
      do_req(5'(i), 1'b0, ~(32'h1 << i), " deny");
    end
    // R5: unimplemented, privileged and fully enabled.
    do_req(5'd6, 1'b1, 32'hFFFF_FFFF, " idx6");
    do_req(5'd31, 1'b1, 32'hFFFF_FFFF, " idx31");
    do_req(5'd17, 1'b0, 32'hFFFF_FFFF, " idx17");
    // R8: both signs of the cycle word.
    cycle_lo = 32'h8000_0001;
    do_req(5'd2, 1'b1, 32'h0, " negative");
    cycle_lo = 32'h7FFF_FFFF;
    do_req(5'd2, 1'b1, 32'h0, " positive");
    // R6 / R11 extremes.
    exc_base_lo = '1;
    do_req(5'd0, 1'b0, 32'h1, " all ones");
    cfg_flag = 1'b1;
    do_req(5'd5, 1'b1, 32'h0, " flag1");
    cfg_flag = 1'b0;
    do_req(5'd5, 1'b1, 32'h0, " flag0");
    // R2: idle after a fault and after a grant.
    do_req(5'd9, 1'b1, 32'h0, " pre-idle");
    do_idle();
    do_req(5'd4, 1'b1, 32'h0, " pre-idle");
    do_idle();
    do_idle();

    for (int n = 0; n < 400; n++) begin
      logic [4:0] ri;
      ri = ($urandom % 4 != 0) ? 5'($urandom % 8) : 5'($urandom);
      randomize_sources();
      do_req(ri, 1'(($urandom % 3) == 0), $urandom, " random");
      if ($urandom % 5 == 0) do_idle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule